// File: doc/BRIEF.md
# Scoreboard Dependency Matrix

This block is the hazard-tracking heart of a small out-of-order issue engine with four function units, eight architectural registers and two speculation shadows. It does not compute, read or write data. It records, one bit at a time, which unit will produce each register, which units still need old register values, and which units were issued under an unresolved branch. From those bits it hands each busy unit two separate permissions: a read grant, which lets the unit fetch its operands, and a write grant, which lets it commit its result.

An instruction enters through the issue port with a target unit, a destination register and two source registers. The execution pipeline reports through a per-unit done strobe when the result is ready. Branch logic opens a shadow slot when it starts speculating and later resolves that slot as correct or mispredicted. A unit issued under an open shadow may read and execute but may not write. A mispredict cancels that unit outright.

Top module: `scoreboard_dep_matrix`

## Requirements
- R1: After reset no unit is busy, every read, write and cancel bit is 0, and an issue request is not stalled.
- R2: `issueStall` is 1 exactly when `issueValid` is 1 and either the target unit is busy or an in-flight unit already owns the requested destination register. A stalled request leaves all state unchanged.
- R3: A busy unit gets `goRead` for one cycle, once per instruction, and only when no older in-flight unit that has not yet written still targets one of its two source registers.
- R4: A unit gets `goWrite` only after a `unitDone` strobe that arrived after its `goRead`, and only while no older in-flight unit that has not yet read names the unit's destination among its sources.
- R5: Opening shadow slot k (bit 0 of `branchOpenId`) makes every unit issued in a later cycle while k stays open unable to receive `goWrite`. Its `goRead` is unaffected. An issue in the same cycle as the open, or in the same cycle as the resolve of k, is not shadowed by k.
- R6: Resolving k as correct (`branchMispredict` = 0) removes k from every unit, and a write held only by k is granted from the next cycle on.
- R7: Resolving k as mispredicted raises `unitCancel` in that cycle for every busy unit issued under k. Each such unit is freed without any write, and its destination is released.
- R8: In its `goWrite` cycle a unit gives up its busy state and its destination register. From the next cycle the unit may be reissued, and consumers blocked on it may be granted.
- R9: Replaying an instruction stream, with writes committed on `goWrite` and operands taken on `goRead`, leaves the register contents equal to in-order execution of the stream with the cancelled instructions removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request this cycle |
| issueUnit | input | 2 | Function unit that receives the instruction |
| issueDest | input | 3 | Destination register |
| issueSrcA | input | 3 | First source register |
| issueSrcB | input | 3 | Second source register |
| issueStall | output | 1 | Request refused this cycle |
| unitDone | input | 4 | Per-unit strobe: execution result ready |
| branchOpen | input | 1 | Open a shadow slot |
| branchOpenId | input | 1 | Slot being opened (must be free) |
| branchResolve | input | 1 | Resolve a shadow slot |
| branchResolveId | input | 1 | Slot being resolved |
| branchMispredict | input | 1 | With resolve: prediction was wrong |
| goRead | output | 4 | Per-unit operand read grant |
| goWrite | output | 4 | Per-unit result write grant |
| unitCancel | output | 4 | Per-unit cancellation pulse on mispredict |

## Verification
On every cycle, the assertions check four properties. A set read-after-write bit always withholds the read grant, and a set write-after-read or shadow bit always withholds the write grant. An accepted issue never lands on an owned register, and a unit never reads twice in a row or writes while being cancelled. Whether the grants fire at the right moment can only be shown by the bench's scenarios: a write released the cycle after a correct resolve, a consumer freed the cycle after its producer writes, a unit reissued straight after its write. The same holds for the end result, that random streams with nested shadows and mispredicts leave the registers equal to in-order execution.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_UNITS   = 4;
  localparam int SB_REGS    = 8;
  localparam int SB_SHADOWS = 2;
  localparam int SB_UNIT_W  = (SB_UNITS > 1) ? $clog2(SB_UNITS) : 1;
  localparam int SB_REG_W   = (SB_REGS > 1) ? $clog2(SB_REGS) : 1;
  localparam int SB_SH_W    = (SB_SHADOWS > 1) ? $clog2(SB_SHADOWS) : 1;

  // Strobes from the grant control into the dependency matrix
  typedef struct packed {
    logic                  issueFire;
    logic [SB_UNIT_W-1:0]  issueUnit;
    logic [SB_REGS-1:0]    destOneHot;
    logic [SB_REGS-1:0]    srcOneHot;
    logic [SB_UNITS-1:0]   liveMask;      // busy and not writing this cycle
    logic [SB_UNITS-1:0]   waitReadMask;  // busy and still owing a read after this cycle
    logic [SB_UNITS-1:0]   readGrant;
    logic [SB_UNITS-1:0]   writeGrant;
    logic [SB_SHADOWS-1:0] shadowNow;     // shadows a new issue falls under
    logic [SB_SHADOWS-1:0] shadowClear;   // slot resolved this cycle
    logic [SB_SHADOWS-1:0] shadowKill;    // slot mispredicted this cycle
  } sbStrobe_t;
endpackage

// File: rtl/sb_dep_matrix.sv
module sb_dep_matrix
  import sb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  sbStrobe_t            strobe,
  output logic [SB_UNITS-1:0]  rawBlocked,
  output logic [SB_UNITS-1:0]  warBlocked,
  output logic [SB_UNITS-1:0]  shadowBlocked,
  output logic [SB_UNITS-1:0]  killHit,
  output logic [SB_REGS-1:0]   regOwned
);
  // unit-versus-register rows
  logic [SB_REGS-1:0]    destOH    [SB_UNITS];
  logic [SB_REGS-1:0]    srcOH     [SB_UNITS];
  // unit-versus-unit rows: row = waiting unit, column = unit it waits on
  logic [SB_UNITS-1:0]   rawDep    [SB_UNITS];
  logic [SB_UNITS-1:0]   warDep    [SB_UNITS];
  // unit-versus-shadow rows
  logic [SB_SHADOWS-1:0] shadowDep [SB_UNITS];

  logic [SB_UNITS-1:0] liveNow;
  logic [SB_UNITS-1:0] waitNow;
  logic [SB_UNITS-1:0] freeCol;

  always_comb begin
    regOwned = '0;
    for (int u = 0; u < SB_UNITS; u++) begin
      rawBlocked[u]    = |rawDep[u];
      warBlocked[u]    = |warDep[u];
      shadowBlocked[u] = |shadowDep[u];
      killHit[u]       = |(shadowDep[u] & strobe.shadowKill);
      regOwned         = regOwned | destOH[u];
    end
    liveNow = strobe.liveMask & ~killHit;
    waitNow = strobe.waitReadMask & ~killHit;
    freeCol = strobe.writeGrant | killHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int u = 0; u < SB_UNITS; u++) begin
        destOH[u]    <= '0;
        srcOH[u]     <= '0;
        rawDep[u]    <= '0;
        warDep[u]    <= '0;
        shadowDep[u] <= '0;
      end
    end else begin
      for (int u = 0; u < SB_UNITS; u++) begin
        if (strobe.issueFire && strobe.issueUnit == SB_UNIT_W'(u)) begin
          destOH[u]    <= strobe.destOneHot;
          srcOH[u]     <= strobe.srcOneHot;
          shadowDep[u] <= strobe.shadowNow;
          for (int v = 0; v < SB_UNITS; v++) begin
            rawDep[u][v] <= liveNow[v] & (|(destOH[v] & strobe.srcOneHot));
            warDep[u][v] <= waitNow[v] & (|(srcOH[v] & strobe.destOneHot));
          end
        end else if (freeCol[u]) begin
          destOH[u]    <= '0;
          srcOH[u]     <= '0;
          rawDep[u]    <= '0;
          warDep[u]    <= '0;
          shadowDep[u] <= '0;
        end else begin
          rawDep[u]    <= rawDep[u] & ~freeCol;
          warDep[u]    <= warDep[u] & ~(strobe.readGrant | killHit);
          shadowDep[u] <= shadowDep[u] & ~strobe.shadowClear;
        end
      end
    end
  end

  // An accepted issue never lands on a register another unit still owns
  p_waw_free_dest_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueFire |-> !(|(regOwned & strobe.destOneHot)));

  for (genvar g = 0; g < SB_UNITS; g++) begin : gRowChk
    p_raw_holds_read_r3: assert property (@(posedge clk) disable iff (!rstN)
      (|rawDep[g]) |-> !strobe.readGrant[g]);
    p_war_holds_write_r4: assert property (@(posedge clk) disable iff (!rstN)
      (|warDep[g]) |-> !strobe.writeGrant[g]);
    p_shadow_holds_write_r5: assert property (@(posedge clk) disable iff (!rstN)
      (|shadowDep[g]) |-> !strobe.writeGrant[g]);
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic [SB_UNIT_W-1:0]  issueUnit,
  input  logic [SB_REG_W-1:0]   issueDest,
  input  logic [SB_REG_W-1:0]   issueSrcA,
  input  logic [SB_REG_W-1:0]   issueSrcB,
  input  logic [SB_UNITS-1:0]   unitDone,
  input  logic                  branchOpen,
  input  logic [SB_SH_W-1:0]    branchOpenId,
  input  logic                  branchResolve,
  input  logic [SB_SH_W-1:0]    branchResolveId,
  input  logic                  branchMispredict,
  input  logic [SB_REGS-1:0]    regOwned,
  input  logic [SB_UNITS-1:0]   rawBlocked,
  input  logic [SB_UNITS-1:0]   warBlocked,
  input  logic [SB_UNITS-1:0]   shadowBlocked,
  input  logic [SB_UNITS-1:0]   killHit,
  output sbStrobe_t             strobe,
  output logic                  issueStall,
  output logic [SB_UNITS-1:0]   goRead,
  output logic [SB_UNITS-1:0]   goWrite,
  output logic [SB_UNITS-1:0]   unitCancel
);
  logic [SB_UNITS-1:0]   busy;
  logic [SB_UNITS-1:0]   readDone;
  logic [SB_UNITS-1:0]   resultReady;
  logic [SB_SHADOWS-1:0] shadowActive;

  logic [SB_REGS-1:0]    destOneHot;
  logic [SB_SHADOWS-1:0] resolveOneHot;
  logic [SB_SHADOWS-1:0] openOneHot;
  logic                  issueFire;

  always_comb begin
    destOneHot    = SB_REGS'(1) << issueDest;
    resolveOneHot = branchResolve ? (SB_SHADOWS'(1) << branchResolveId) : '0;
    openOneHot    = branchOpen ? (SB_SHADOWS'(1) << branchOpenId) : '0;
    issueStall    = issueValid & (busy[issueUnit] | (|(regOwned & destOneHot)));
    issueFire     = issueValid & ~issueStall;
    goRead        = busy & ~readDone & ~rawBlocked;
    goWrite       = busy & resultReady & ~warBlocked & ~shadowBlocked;
    unitCancel    = busy & killHit;
  end

  always_comb begin
    strobe.issueFire    = issueFire;
    strobe.issueUnit    = issueUnit;
    strobe.destOneHot   = destOneHot;
    strobe.srcOneHot    = (SB_REGS'(1) << issueSrcA) | (SB_REGS'(1) << issueSrcB);
    strobe.liveMask     = busy & ~goWrite;
    strobe.waitReadMask = busy & ~readDone & ~goRead;
    strobe.readGrant    = goRead;
    strobe.writeGrant   = goWrite;
    strobe.shadowNow    = shadowActive & ~resolveOneHot;
    strobe.shadowClear  = resolveOneHot;
    strobe.shadowKill   = branchMispredict ? resolveOneHot : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy         <= '0;
      readDone     <= '0;
      resultReady  <= '0;
      shadowActive <= '0;
    end else begin
      shadowActive <= (shadowActive & ~resolveOneHot) | openOneHot;
      for (int u = 0; u < SB_UNITS; u++) begin
        if (issueFire && issueUnit == SB_UNIT_W'(u)) begin
          busy[u]        <= 1'b1;
          readDone[u]    <= 1'b0;
          resultReady[u] <= 1'b0;
        end else if (goWrite[u] || killHit[u]) begin
          busy[u]        <= 1'b0;
          readDone[u]    <= 1'b0;
          resultReady[u] <= 1'b0;
        end else begin
          if (goRead[u]) readDone[u] <= 1'b1;
          if (unitDone[u] && busy[u] && readDone[u]) resultReady[u] <= 1'b1;
        end
      end
    end
  end

  // A slot is only opened when free
  p_open_free_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    branchOpen |-> !shadowActive[branchOpenId]);

  for (genvar g = 0; g < SB_UNITS; g++) begin : gUnitChk
    p_single_read_r3: assert property (@(posedge clk) disable iff (!rstN)
      goRead[g] |=> !goRead[g]);
    p_cancel_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
      unitCancel[g] |-> !goWrite[g]);
    p_one_write_r8: assert property (@(posedge clk) disable iff (!rstN)
      goWrite[g] |=> !goWrite[g]);
  end
endmodule

// File: rtl/scoreboard_dep_matrix.sv
module scoreboard_dep_matrix
  import sb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  issueValid,
  input  logic [SB_UNIT_W-1:0]  issueUnit,
  input  logic [SB_REG_W-1:0]   issueDest,
  input  logic [SB_REG_W-1:0]   issueSrcA,
  input  logic [SB_REG_W-1:0]   issueSrcB,
  output logic                  issueStall,
  input  logic [SB_UNITS-1:0]   unitDone,
  input  logic                  branchOpen,
  input  logic [SB_SH_W-1:0]    branchOpenId,
  input  logic                  branchResolve,
  input  logic [SB_SH_W-1:0]    branchResolveId,
  input  logic                  branchMispredict,
  output logic [SB_UNITS-1:0]   goRead,
  output logic [SB_UNITS-1:0]   goWrite,
  output logic [SB_UNITS-1:0]   unitCancel
);
  sbStrobe_t           strobe;
  logic [SB_UNITS-1:0] rawBlocked;
  logic [SB_UNITS-1:0] warBlocked;
  logic [SB_UNITS-1:0] shadowBlocked;
  logic [SB_UNITS-1:0] killHit;
  logic [SB_REGS-1:0]  regOwned;

  sb_issue_ctrl i_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .issueValid       (issueValid),
    .issueUnit        (issueUnit),
    .issueDest        (issueDest),
    .issueSrcA        (issueSrcA),
    .issueSrcB        (issueSrcB),
    .unitDone         (unitDone),
    .branchOpen       (branchOpen),
    .branchOpenId     (branchOpenId),
    .branchResolve    (branchResolve),
    .branchResolveId  (branchResolveId),
    .branchMispredict (branchMispredict),
    .regOwned         (regOwned),
    .rawBlocked       (rawBlocked),
    .warBlocked       (warBlocked),
    .shadowBlocked    (shadowBlocked),
    .killHit          (killHit),
    .strobe           (strobe),
    .issueStall       (issueStall),
    .goRead           (goRead),
    .goWrite          (goWrite),
    .unitCancel       (unitCancel)
  );

  sb_dep_matrix i_matrix (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .rawBlocked    (rawBlocked),
    .warBlocked    (warBlocked),
    .shadowBlocked (shadowBlocked),
    .killHit       (killHit),
    .regOwned      (regOwned)
  );
endmodule

// File: tb/test_scoreboard_dep_matrix.sv
module test_scoreboard_dep_matrix;
  localparam int NU = 4;
  localparam int NR = 8;
  localparam int NS = 2;
  localparam int LOGN = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [1:0] issueUnit = '0;
  logic [2:0] issueDest = '0, issueSrcA = '0, issueSrcB = '0;
  logic issueStall;
  logic [NU-1:0] unitDone = '0;
  logic branchOpen = 1'b0;
  logic [0:0] branchOpenId = '0;
  logic branchResolve = 1'b0;
  logic [0:0] branchResolveId = '0;
  logic branchMispredict = 1'b0;
  logic [NU-1:0] goRead, goWrite, unitCancel;

  always #4 clk = ~clk;

  scoreboard_dep_matrix i_scoreboard_dep_matrix (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .issueDest(issueDest), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueStall(issueStall), .unitDone(unitDone), .branchOpen(branchOpen),
    .branchOpenId(branchOpenId), .branchResolve(branchResolve),
    .branchResolveId(branchResolveId), .branchMispredict(branchMispredict),
    .goRead(goRead), .goWrite(goWrite), .unitCancel(unitCancel)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // behavioural model
  bit mBusy[NU], mRead[NU], mReady[NU];
  int mDest[NU], mSrcA[NU], mSrcB[NU], mSeq[NU], mRec[NU], opA[NU], opB[NU];
  bit [NS-1:0] mShadow[NU];
  bit [NS-1:0] mActive = '0;
  int rf[NR], rfRef[NR];
  int logDest[LOGN], logA[LOGN], logB[LOGN], logSeq[LOGN];
  bit logKill[LOGN];
  int logCount = 0;
  int seqCounter = 0;
  bit [NU-1:0] lastWrite = '0;
  int stStall = 0, stRaw = 0, stWar = 0, stShRead = 0, stHeld = 0;
  int stRelease = 0, stCancel = 0, stReissue = 0;

  task automatic check(bit ok, string tag, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int calc(int a, int b, int s);
    return (a ^ (b << 1)) + s;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic evalAndUpdate();
    bit [NU-1:0] eR, eW, eC, dn;
    bit eS;
    int iu;
    #1;
    eS = 0;
    if (issueValid) begin
      eS = mBusy[issueUnit];
      for (int v = 0; v < NU; v++) if (mBusy[v] && mDest[v] == int'(issueDest)) eS = 1;
    end
    for (int u = 0; u < NU; u++) begin
      eR[u] = mBusy[u] && !mRead[u];
      eW[u] = mBusy[u] && mReady[u] && mShadow[u] == 0;
      if (mBusy[u] && mReady[u] && mShadow[u] != 0) stHeld++;
      for (int v = 0; v < NU; v++) begin
        if (v != u && mBusy[v] && mBusy[u] && mSeq[v] < mSeq[u]) begin
          if (!mRead[u] && (mDest[v] == mSrcA[u] || mDest[v] == mSrcB[u])) begin
            if (eR[u]) stRaw++;
            eR[u] = 0;
          end
          if (!mRead[v] && (mSrcA[v] == mDest[u] || mSrcB[v] == mDest[u])) begin
            if (eW[u]) stWar++;
            eW[u] = 0;
          end
        end
      end
      if (eR[u] && mShadow[u] != 0) stShRead++;
      eC[u] = branchResolve && branchMispredict && mBusy[u] && mShadow[u][branchResolveId];
      if (eW[u] && mShadow[u] == 0 && mReady[u] && branchResolve == 0) ;
    end
    check(issueStall == eS, "R2 issueStall", int'(issueStall), int'(eS));
    check(goRead == eR, "R3 goRead", int'(goRead), int'(eR));
    check(goWrite == eW, "R4/R5/R6/R8 goWrite", int'(goWrite), int'(eW));
    check(unitCancel == eC, "R7 unitCancel", int'(unitCancel), int'(eC));
    if (eS) stStall++;
    // model update
    for (int u = 0; u < NU; u++) dn[u] = unitDone[u] && mBusy[u] && mRead[u] && !eC[u];
    for (int u = 0; u < NU; u++) if (eR[u]) begin
      opA[u] = rf[mSrcA[u]]; opB[u] = rf[mSrcB[u]]; mRead[u] = 1;
    end
    for (int u = 0; u < NU; u++) if (eW[u]) begin
      rf[mDest[u]] = calc(opA[u], opB[u], mSeq[u]);
      mBusy[u] = 0; mRead[u] = 0; mReady[u] = 0; mShadow[u] = '0;
    end
    for (int u = 0; u < NU; u++) if (eC[u]) begin
      logKill[mRec[u]] = 1; stCancel++;
      mBusy[u] = 0; mRead[u] = 0; mReady[u] = 0; mShadow[u] = '0;
    end
    for (int u = 0; u < NU; u++) if (dn[u] && mBusy[u]) mReady[u] = 1;
    if (branchResolve) begin
      for (int u = 0; u < NU; u++) begin
        if (!branchMispredict && mBusy[u] && mReady[u] && mShadow[u] == (NS'(1) << branchResolveId))
          stRelease++;
        mShadow[u][branchResolveId] = 1'b0;
      end
      mActive[branchResolveId] = 1'b0;
    end
    if (issueValid && !eS) begin
      iu = int'(issueUnit);
      if (lastWrite[iu]) stReissue++;
      mBusy[iu] = 1; mRead[iu] = 0; mReady[iu] = 0;
      mDest[iu] = issueDest; mSrcA[iu] = issueSrcA; mSrcB[iu] = issueSrcB;
      mSeq[iu] = seqCounter; mRec[iu] = logCount; mShadow[iu] = mActive;
      logDest[logCount] = issueDest; logA[logCount] = issueSrcA; logB[logCount] = issueSrcB;
      logSeq[logCount] = seqCounter; logKill[logCount] = 0;
      logCount++; seqCounter++;
    end
    if (branchOpen) mActive[branchOpenId] = 1'b1;
    lastWrite = eW;
  endtask

  task automatic driveRandom(bit allowNew);
    int r;
    issueValid = allowNew && ($urandom % 2 == 0) && logCount < LOGN - 1;
    issueUnit = 2'($urandom % NU);
    issueDest = 3'($urandom % NR);
    issueSrcA = 3'($urandom % NR);
    issueSrcB = 3'($urandom % NR);
    for (int u = 0; u < NU; u++)
      unitDone[u] = mBusy[u] && mRead[u] && !mReady[u] && ($urandom % 3 == 0);
    branchOpen = 0; branchResolve = 0; branchMispredict = 0;
    r = $urandom % 16;
    if (allowNew && r == 0 && mActive != '1) begin
      branchOpen = 1;
      branchOpenId = mActive[0] ? 1'b1 : 1'b0;
      if (!mActive[0] && !mActive[1]) branchOpenId = 1'($urandom % 2);
    end else if ((r <= 2 || !allowNew) && mActive != '0) begin
      branchResolve = 1;
      branchResolveId = mActive[0] ? 1'b0 : 1'b1;
      if (mActive == '1) branchResolveId = 1'($urandom % 2);
      branchMispredict = allowNew && ($urandom % 3 == 0);
    end
  endtask

  initial begin
    int busyAny;
    for (int i = 0; i < NR; i++) begin rf[i] = i * 37 + 11; rfRef[i] = rf[i]; end
    for (int u = 0; u < NU; u++) begin
      mBusy[u] = 0; mRead[u] = 0; mReady[u] = 0; mShadow[u] = '0;
      mDest[u] = 0; mSrcA[u] = 0; mSrcB[u] = 0; mSeq[u] = 0; mRec[u] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(goRead == '0, "R1 goRead after reset", int'(goRead), 0);
    check(goWrite == '0, "R1 goWrite after reset", int'(goWrite), 0);
    check(unitCancel == '0, "R1 unitCancel after reset", int'(unitCancel), 0);
    check(issueStall == 1'b0, "R1 issueStall idle", int'(issueStall), 0);
    issueValid = 1'b1; issueUnit = 2'd3; issueDest = 3'd7;
    #1;
    check(issueStall == 1'b0, "R1 issue accepted after reset", int'(issueStall), 0);
    issueValid = 1'b0;

    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      driveRandom(1'b1);
      evalAndUpdate();
    end
    for (int c = 0; c < 3000; c++) begin
      busyAny = 0;
      for (int u = 0; u < NU; u++) if (mBusy[u]) busyAny = 1;
      if (!busyAny && mActive == '0) break;
      @(negedge clk);
      driveRandom(1'b0);
      evalAndUpdate();
    end
    @(negedge clk);
    issueValid = 0; unitDone = '0; branchOpen = 0; branchResolve = 0;
    #1;
    check(goRead == '0 && goWrite == '0, "R8 drained to idle",
          int'({goRead, goWrite}), 0);

    // R9: in-order reference with cancelled instructions dropped
    for (int i = 0; i < logCount; i++)
      if (!logKill[i]) rfRef[logDest[i]] = calc(rfRef[logA[i]], rfRef[logB[i]], logSeq[i]);
    for (int i = 0; i < NR; i++)
      check(rf[i] == rfRef[i], $sformatf("R9 register %0d", i), rf[i], rfRef[i]);

    // scenario coverage
    check(stStall > 0, "R2 stall cases seen", stStall, 1);
    check(stRaw > 0, "R3 read held by producer seen", stRaw, 1);
    check(stWar > 0, "R4 write held by older reader seen", stWar, 1);
    check(stShRead > 0 && stHeld > 0, "R5 shadowed read with held write seen", stShRead, 1);
    check(stRelease > 0, "R6 held write released by resolve seen", stRelease, 1);
    check(stCancel > 0, "R7 cancellation seen", stCancel, 1);
    check(stReissue > 0, "R8 reissue right after write seen", stReissue, 1);
    finishRun();
  end

  initial begin
    #(8 * 150000);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end
endmodule